// File: doc/BRIEF.md
# Register-Mapped General-Purpose I/O Controller

This block is a general-purpose I/O peripheral. Software reaches it through a minimal single-cycle register port: an address, a write enable, write data and combinational read data. Inside are an output value latch and a direction register. From these it drives the per-line controls of a tri-state pad: a drive value and a drive enable. The input side of each pad passes through a two-flop synchroniser. Software sees the synchronised levels when it reads the data register.

Three choices are fixed when the block is built.

- **Write style.**
  - *Plain:* a single data word is written directly.
  - *Set/clear:* a write-one-to-set register and a write-one-to-clear register are provided.
  - *Set-only:* a set register holds the whole output word.
- **Direction style.**
  - *None:* every line is always driven.
  - *Output-polarity:* a 1 means the line drives.
  - *Input-polarity:* a 1 means the line only listens.
- **Line numbering.** Lines are numbered either LSB-first or MSB-first against register bits.

The register width is 8, 16, 32 or 64 bits. There is one line per bit.

Top module: `gpio_regbank_ctl`

## Requirements
- R1: After reset the output latch is all 0 and every line is an input. In the output-polarity style this means a direction register of all 0. In the input-polarity style it means all 1. In both styles `pin_oe` is all 0.
- R2: In plain write style, a write to offset 0 replaces the output latch with the written word. With no direction register, `pin_oe` is all 1.
- R3: In set/clear style, a write to offset 1 drives high each line whose register bit is written 1 and leaves lines written 0 unchanged. Writes to offset 0 are ignored.
- R4: In set/clear style, a write to offset 2 drives low each line whose register bit is written 1 and leaves the other lines unchanged. Offsets 1 and 2 both read as 0.
- R5: In set-only style, a write to offset 1 replaces the whole output latch: a 1 bit drives the line high and a 0 bit drives it low. Offset 1 reads back the latch, and writes to offset 0 are ignored.
- R6: In the output-polarity direction style, offset 3 reads back what was written. A register bit of 1 asserts that line's `pin_oe` on the clock edge of the write.
- R7: In the input-polarity direction style, offset 3 reads back what was written. A register bit of 1 deasserts that line's `pin_oe`, and a bit of 0 asserts it.
- R8: With MSB-first numbering, line n corresponds to register bit WIDTH-1-n. This applies to `pin_out`, `pin_oe` and data-register reads. With LSB-first numbering, line n corresponds to bit n.
- R9: A read of offset 0 returns the `pin_in` levels after exactly two rising clock edges. A level that has passed only one edge is not yet visible.
- R10: The register offsets are data 0, set 1, clear 2 and direction 3. A register that the selected styles do not provide reads as 0 and ignores writes. Any cycle without an accepted write leaves the latch and the direction register unchanged.
- R11: Writes update the output latch bit of a line even while that line is an input. The stored value then appears on `pin_out` and is driven as soon as the line is switched to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset in units of the register width |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Combinational read data for `addr` |
| pin_in | input | WIDTH | Pad input levels, indexed by line number |
| pin_out | output | WIDTH | Pad drive values, indexed by line number |
| pin_oe | output | WIDTH | Pad drive enables, indexed by line number |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- the bit-wise effect of set, clear and whole-word writes on the latch;
- that the latch and direction register hold in any cycle without an accepted write;
- how a direction write maps onto `pin_oe`, through both the polarity and the line order;
- the exact two-edge delay of the input synchroniser.

Other behaviour can only be shown by the bench's scenarios across three build variants:
- the reset values;
- what each register reads back;
- that writes to registers a variant lacks are ignored;
- MSB-first line reversal on the visible pins;
- a latch value written while a line is an input and then exposed when the line switches to output.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

  localparam int unsigned ADDR_W = 2;

  // Offsets in units of the register width
  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_SET  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd3;

  typedef enum logic [1:0] {
    WS_PLAIN   = 2'd0,
    WS_SETCLR  = 2'd1,
    WS_SETONLY = 2'd2
  } wr_style_e;

  typedef enum logic [1:0] {
    DS_NONE = 2'd0,
    DS_OUT  = 2'd1,
    DS_IN   = 2'd2
  } dir_style_e;

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
#(
  parameter wr_style_e  WR_STYLE  = WS_SETCLR,
  parameter dir_style_e DIR_STYLE = DS_OUT
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              stb_dat,
  output logic              stb_set,
  output logic              stb_clr,
  output logic              stb_dir
);

  localparam bit HAS_DAT_WR = (WR_STYLE == WS_PLAIN);
  localparam bit HAS_SET    = (WR_STYLE != WS_PLAIN);
  localparam bit HAS_CLR    = (WR_STYLE == WS_SETCLR);
  localparam bit HAS_DIR    = (DIR_STYLE != DS_NONE);

  // Only registers that exist for this build produce a strobe
  always_comb begin
    stb_dat = wr_en && (addr == OFS_DATA) && HAS_DAT_WR;
    stb_set = wr_en && (addr == OFS_SET)  && HAS_SET;
    stb_clr = wr_en && (addr == OFS_CLR)  && HAS_CLR;
    stb_dir = wr_en && (addr == OFS_DIR)  && HAS_DIR;
  end

  // R10: a single address can select at most one register
  always_comb begin
    p_one_strobe_r10: assert ($onehot0({stb_dat, stb_set, stb_clr, stb_dir}))
      else $error("more than one register strobe");
  end

endmodule

// File: rtl/gpio_rb_state.sv
module gpio_rb_state
  import gpio_rb_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter wr_style_e   WR_STYLE  = WS_SETCLR,
  parameter dir_style_e  DIR_STYLE = DS_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_dat,
  input  logic             stb_set,
  input  logic             stb_clr,
  input  logic             stb_dir,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);

  // All lines start as inputs, whatever the polarity
  localparam logic [WIDTH-1:0] DIR_RST = (DIR_STYLE == DS_IN) ? '1 : '0;

  function automatic logic [WIDTH-1:0] next_latch(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] wd,
    input logic dat, input logic set, input logic clr);
    logic [WIDTH-1:0] n;
    n = cur;
    if (WR_STYLE == WS_SETCLR) begin
      if (set) n = cur | wd;
      if (clr) n = n & ~wd;
    end else begin
      if (dat || set) n = wd;
    end
    return n;
  endfunction

  logic             latch_wr;
  logic [WIDTH-1:0] latch_d;

  assign latch_wr = stb_dat | stb_set | stb_clr;
  assign latch_d  = next_latch(latch_q, wr_data, stb_dat, stb_set, stb_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_wr) begin
      latch_q <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
    end else if (stb_dir) begin
      dir_q <= wr_data;
    end
  end

  // R3: set raises the written ones and keeps every other bit
  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_set && WR_STYLE == WS_SETCLR) |=>
      (((latch_q & $past(wr_data)) == $past(wr_data)) &&
       ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data)))))
    else $error("set write wrong");

  // R4: clear lowers the written ones and keeps every other bit
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_clr |=>
      (((latch_q & $past(wr_data)) == '0) &&
       ((latch_q & ~$past(wr_data)) == ($past(latch_q) & ~$past(wr_data)))))
    else $error("clear write wrong");

  // R5: the set-only register takes the whole word
  p_word_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_set && WR_STYLE == WS_SETONLY) |=> (latch_q == $past(wr_data)))
    else $error("whole-word set wrong");

  // R10: no accepted write means no state change
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_wr || stb_dir) |=> ($stable(latch_q) && $stable(dir_q)))
    else $error("state changed without a write");

endmodule

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int unsigned STAGES = 2;

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

  // Assertion support: edges seen since reset, saturating at two
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  // R9: the output is the input of exactly two edges ago
  p_two_edge_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2)))
    else $error("synchroniser delay wrong");

endmodule

// File: rtl/gpio_regbank_ctl.sv
module gpio_regbank_ctl
  import gpio_rb_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter wr_style_e   WR_STYLE  = WS_SETCLR,
  parameter dir_style_e  DIR_STYLE = DS_OUT,
  parameter bit          MSB_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  // Register bit order <-> line order; the map is its own inverse
  function automatic logic [WIDTH-1:0] line_order(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      r[i] = MSB_FIRST ? v[WIDTH-1-i] : v[i];
    end
    return r;
  endfunction

  // Drive enable in register order from the direction register
  function automatic logic [WIDTH-1:0] drive_mask(input logic [WIDTH-1:0] d);
    logic [WIDTH-1:0] m;
    case (DIR_STYLE)
      DS_OUT:  m = d;
      DS_IN:   m = ~d;
      default: m = '1;
    endcase
    return m;
  endfunction

  logic             stb_dat, stb_set, stb_clr, stb_dir;
  logic [WIDTH-1:0] latch_q, dir_q, pins_sync;

  gpio_rb_decode #(
    .WR_STYLE (WR_STYLE),
    .DIR_STYLE(DIR_STYLE)
  ) u_decode (
    .wr_en  (wr_en),
    .addr   (addr),
    .stb_dat(stb_dat),
    .stb_set(stb_set),
    .stb_clr(stb_clr),
    .stb_dir(stb_dir)
  );

  gpio_rb_state #(
    .WIDTH    (WIDTH),
    .WR_STYLE (WR_STYLE),
    .DIR_STYLE(DIR_STYLE)
  ) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_dat(stb_dat),
    .stb_set(stb_set),
    .stb_clr(stb_clr),
    .stb_dir(stb_dir),
    .wr_data(wr_data),
    .latch_q(latch_q),
    .dir_q  (dir_q)
  );

  gpio_rb_sync #(
    .WIDTH(WIDTH)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pin_in),
    .sync_out(pins_sync)
  );

  assign pin_out = line_order(latch_q);
  assign pin_oe  = line_order(drive_mask(dir_q));

  always_comb begin
    case (addr)
      OFS_DATA: rd_data = line_order(pins_sync);
      OFS_SET:  rd_data = (WR_STYLE == WS_SETONLY) ? latch_q : '0;
      OFS_DIR:  rd_data = (DIR_STYLE != DS_NONE) ? dir_q : '0;
      default:  rd_data = '0;
    endcase
  end

  // R6/R7: a direction write lands on the enables in the chosen polarity and order
  p_dir_apply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_dir |=> (pin_oe == line_order((DIR_STYLE == DS_IN) ? ~$past(wr_data)
                                                           : $past(wr_data))))
    else $error("direction write not applied to pin_oe");

  // R11: a latch write shows on pin_out whatever the line direction
  p_latch_visible_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_dat || (stb_set && WR_STYLE == WS_SETONLY)) |=> (pin_out == line_order($past(wr_data))))
    else $error("latch write not visible on pin_out");

endmodule

// File: tb/tb_gpio_regbank_ctl.sv
`timescale 1ns/1ps
module tb_gpio_regbank_ctl;
  import gpio_rb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [1:0]  addr = '0;
  logic [15:0] wd = '0;
  logic we_a = 1'b0, we_b = 1'b0, we_c = 1'b0;
  logic [7:0]  rd_a, pin_in_a = '0, out_a, oe_a;
  logic [7:0]  rd_b, pin_in_b = '0, out_b, oe_b;
  logic [15:0] rd_c, pin_in_c = '0, out_c, oe_c;

  // Variant A: set/clear, output-polarity direction, LSB-first
  gpio_regbank_ctl #(.WIDTH(8), .WR_STYLE(WS_SETCLR), .DIR_STYLE(DS_OUT), .MSB_FIRST(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(we_a), .wr_data(wd[7:0]),
    .rd_data(rd_a), .pin_in(pin_in_a), .pin_out(out_a), .pin_oe(oe_a));

  // Variant B: set-only, input-polarity direction, MSB-first
  gpio_regbank_ctl #(.WIDTH(8), .WR_STYLE(WS_SETONLY), .DIR_STYLE(DS_IN), .MSB_FIRST(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(we_b), .wr_data(wd[7:0]),
    .rd_data(rd_b), .pin_in(pin_in_b), .pin_out(out_b), .pin_oe(oe_b));

  // Variant C: plain data register, no direction register, LSB-first
  gpio_regbank_ctl #(.WIDTH(16), .WR_STYLE(WS_PLAIN), .DIR_STYLE(DS_NONE), .MSB_FIRST(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(we_c), .wr_data(wd),
    .rd_data(rd_c), .pin_in(pin_in_c), .pin_out(out_c), .pin_oe(oe_c));

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int sel, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wd = d;
    we_a = (sel == 0); we_b = (sel == 1); we_c = (sel == 2);
    @(posedge clk);
    #1;
    we_a = 1'b0; we_b = 1'b0; we_c = 1'b0;
  endtask

  task automatic bus_addr(input logic [1:0] a);
    @(negedge clk);
    addr = a;
    #1;
  endtask

  // Variant A vectors: {offset, write data, expected pin_out, expected pin_oe}
  localparam int NV = 8;
  localparam logic [25:0] VEC_A [NV] = '{
    {2'd1, 8'h0F, 8'h0F, 8'h00},   // R3 set low nibble
    {2'd3, 8'hF0, 8'h0F, 8'hF0},   // R6 upper lines drive
    {2'd2, 8'h03, 8'h0C, 8'hF0},   // R4 clear two bits
    {2'd1, 8'h80, 8'h8C, 8'hF0},   // R3 others kept
    {2'd2, 8'h00, 8'h8C, 8'hF0},   // R4 zeros do nothing
    {2'd0, 8'hFF, 8'h8C, 8'hF0},   // R3 data write ignored
    {2'd3, 8'hFF, 8'h8C, 8'hFF},   // R6 all drive
    {2'd1, 8'h00, 8'h8C, 8'hFF}    // R3 zero set no effect
  };

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_addr(2'd3);
    check("R1 A pin_out", {8'h0, out_a}, 16'h0000);
    check("R1 A pin_oe", {8'h0, oe_a}, 16'h0000);
    check("R1 A dir read", {8'h0, rd_a}, 16'h0000);
    check("R1 B pin_oe", {8'h0, oe_b}, 16'h0000);
    check("R1 B dir read", {8'h0, rd_b}, 16'h00FF);
    check("R2 C pin_oe all driven", oe_c, 16'hFFFF);
    check("R1 C pin_out", out_c, 16'h0000);
    bus_addr(2'd1);
    check("R4 A set reads 0", {8'h0, rd_a}, 16'h0000);

    // Vector table on variant A
    for (int i = 0; i < NV; i++) begin
      bus_write(0, VEC_A[i][25:24], {8'h0, VEC_A[i][23:16]});
      check($sformatf("R3/R4/R6 vector %0d pin_out", i), {8'h0, out_a}, {8'h0, VEC_A[i][15:8]});
      check($sformatf("R3/R4/R6 vector %0d pin_oe", i), {8'h0, oe_a}, {8'h0, VEC_A[i][7:0]});
    end
    bus_addr(2'd3);
    check("R6 A dir readback", {8'h0, rd_a}, 16'h00FF);
    bus_addr(2'd2);
    check("R4 A clear reads 0", {8'h0, rd_a}, 16'h0000);

    // R9 synchroniser delay on A
    @(negedge clk);
    addr = 2'd0;
    pin_in_a = 8'h3C;
    @(posedge clk); #1;
    check("R9 A one edge not visible", {8'h0, rd_a}, 16'h0000);
    @(posedge clk); #1;
    check("R9 A two edges visible", {8'h0, rd_a}, 16'h003C);

    // Variant B: whole-word set, input polarity, MSB-first
    bus_write(1, 2'd1, 16'h0001);
    check("R8 B reg bit0 is line7", {8'h0, out_b}, 16'h0080);
    bus_addr(2'd1);
    check("R5 B set readback", {8'h0, rd_b}, 16'h0001);
    bus_write(1, 2'd0, 16'h0055);
    check("R5 B data write ignored", {8'h0, out_b}, 16'h0080);
    bus_write(1, 2'd3, 16'h00FE);
    check("R7 B dir 0 drives line7", {8'h0, oe_b}, 16'h0080);
    bus_write(1, 2'd1, 16'h0003);
    check("R5 R11 B latch while input", {8'h0, out_b}, 16'h00C0);
    check("R11 B line6 still input", {8'h0, oe_b}, 16'h0080);
    bus_write(1, 2'd3, 16'h00FC);
    check("R11 B line6 now drives", {8'h0, oe_b}, 16'h00C0);
    check("R11 B value kept", {8'h0, out_b}, 16'h00C0);
    bus_write(1, 2'd1, 16'h0002);
    check("R5 B whole word replaces", {8'h0, out_b}, 16'h0040);
    @(negedge clk);
    addr = 2'd0;
    pin_in_b = 8'h01;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R8 R9 B line0 read at bit7", {8'h0, rd_b}, 16'h0080);

    // Variant C: plain data register, no direction register
    bus_write(2, 2'd0, 16'hA5A5);
    check("R2 C data write", out_c, 16'hA5A5);
    bus_write(2, 2'd1, 16'h0F0F);
    check("R10 C set ignored", out_c, 16'hA5A5);
    bus_write(2, 2'd3, 16'h0000);
    check("R10 C dir ignored", oe_c, 16'hFFFF);
    bus_addr(2'd3);
    check("R10 C dir reads 0", rd_c, 16'h0000);
    bus_addr(2'd1);
    check("R10 C set reads 0", rd_c, 16'h0000);
    @(negedge clk);
    addr = 2'd0;
    pin_in_c = 16'h1234;
    @(posedge clk); #1;
    check("R9 C one edge", rd_c, 16'h0000);
    @(posedge clk); #1;
    check("R9 C two edges", rd_c, 16'h1234);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule